// File: doc/BRIEF.md
# Control Endpoint Status and Stall Controller

This block holds the status register and protocol checks for the default control pipe of a USB device. A packet engine presents each transaction as a one-cycle strobe. The strobe carries the token kind, whether the data toggle was valid, the received payload length, and whether the transaction belongs to the status stage. One clock edge later the block answers with the handshake to send: ACK, NAK or STALL. In the same edge it updates the flags that firmware reads through an 8-bit register.

The block detects protocol violations on its own. When it finds one, it stalls exactly one transaction and abandons the control transfer in progress. A SETUP whose toggle is wrong is still acknowledged, and the stall is held over to the next data transaction. If a transfer is cut short before its announced data has moved, that is reported in its own flag, separate from the arrival of a new SETUP.

A three-state transfer tracker follows the control transfer. CT_IDLE goes to CT_DATA on any SETUP. CT_DATA goes to CT_STATUS once DATA_END is set. CT_DATA or CT_STATUS goes to CT_IDLE on an acknowledged status-stage transaction or on a hardware stall. A SETUP from any state re-enters CT_DATA.

Top module: `ep0_ctrl_status`

## Requirements
- R1: After reset, and whenever reset is asserted, the register reads 0x00 and `hs_valid` is low.
- R2: Token kinds are encoded as SETUP=0, OUT=1, and any other code is IN. Handshake codes are ACK=0, NAK=1, STALL=2, and the handshake is given one edge after `txn_valid`. A SETUP is always ACKed. It sets bit 0 (OUT_READY), clears bit 1 (IN_READY) and bit 3 (DATA_END), and drops any held-over stall.
- R3: A SETUP with a bad toggle is ACKed. The next OUT or IN is then STALLed and sets bit 4 (HW_STALL).
- R4: Outside the status stage, an IN or OUT while DATA_END=1 is STALLed. An OUT longer than MAX_PKT is also STALLed. Each of these sets HW_STALL and clears DATA_END.
- R5: A status-stage transaction with a bad toggle is STALLed and sets HW_STALL.
- R6: A hardware stall covers one transaction only. The next transaction gets its normal handshake, and the transfer tracker returns to CT_IDLE.
- R7: Bit 2 (CPU_STALL) is a plain read/write bit. While it is 1, every OUT and IN is STALLed and HW_STALL is left unchanged.
- R8: A NAK is sent for an OUT while OUT_READY=1, and for an IN while IN_READY=0. Otherwise the handshake is ACK. An ACKed data-stage OUT sets OUT_READY; a status-stage OUT does not. An OUT of exactly MAX_PKT bytes is accepted.
- R9: Writing 1 to IN_READY sets it, and writing 0 has no effect. The `in_acked` strobe clears it.
- R10: Writing 0 to HW_STALL clears it, and writing 1 has no effect.
- R11: Bit 5 (EARLY_END) is set in two cases while the tracker is in CT_DATA with DATA_END=0: a SETUP arrives, or a status-stage transaction is ACKed. Writing 1 to bit 7 clears it. Writing bit 5 directly has no effect. Bits 6 and 7 read as 0. A transfer that ends normally leaves EARLY_END at 0.
- R12: Writing 1 to bit 6 clears OUT_READY. Writing bit 0 directly has no effect.
- R13: When a hardware set and a CPU clear hit the same bit in one cycle, the hardware set wins. OUT_READY and EARLY_END may rise in the same edge.
- R14: Writing 1 to DATA_END sets it, and writing 0 has no effect. A SETUP or a hardware stall clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | One-cycle transaction strobe |
| txn_kind | input | 2 | Token kind (0 SETUP, 1 OUT, other IN) |
| txn_toggle_ok | input | 1 | Data toggle was as expected |
| txn_status | input | 1 | Transaction belongs to the status stage |
| txn_len | input | LEN_W | Received payload length in bytes |
| in_acked | input | 1 | Host acknowledged the IN data packet |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read value |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake (0 ACK, 1 NAK, 2 STALL) |

## Verification
Both the handshake and every register update become visible exactly one rising edge after the strobe or write that causes them. The read path adds no further delay. The only slower effect is that a DATA_END write moves the tracker to CT_STATUS one edge later still, so the stimulus inserts an idle row before any status transaction that depends on it. Each row of stimulus is driven at a falling edge and its results are compared at the next falling edge, which is one rising edge later.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
    typedef enum logic [1:0] {TK_SETUP = 2'd0, TK_OUT = 2'd1, TK_IN = 2'd2} tok_e;
    typedef enum logic [1:0] {HS_ACK = 2'd0, HS_NAK = 2'd1, HS_STALL = 2'd2} hs_e;
    typedef enum logic [1:0] {CT_IDLE = 2'd0, CT_DATA = 2'd1, CT_STATUS = 2'd2} ctl_e;

    localparam int B_OUT_RDY  = 0;
    localparam int B_IN_RDY   = 1;
    localparam int B_CPU_STL  = 2;
    localparam int B_DATA_END = 3;
    localparam int B_HW_STL   = 4;
    localparam int B_EARLY    = 5;
    localparam int B_SVC_OUT  = 6;
    localparam int B_SVC_END  = 7;
endpackage

// File: rtl/ep0_xfer_fsm.sv
module ep0_xfer_fsm
    import ep0_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int LEN_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_valid,
    input  logic [1:0]       txn_kind,
    input  logic             txn_toggle_ok,
    input  logic             txn_status,
    input  logic [LEN_W-1:0] txn_len,
    input  logic             out_rdy,
    input  logic             in_rdy,
    input  logic             cpu_stall,
    input  logic             data_end,
    output logic             ev_setup,
    output logic             ev_out_ack,
    output logic             ev_hw_stall,
    output logic             ev_early_end,
    output logic             hs_valid,
    output logic [1:0]       hs_code
);
    localparam logic [LEN_W-1:0] MAX_LIM = LEN_W'(MAX_PKT);

    ctl_e state_q, state_d;
    logic defer_q, defer_d;
    hs_e  code_d, code_q;
    logic is_setup, is_out, violation, ack_data, status_ack;

    always_comb begin
        is_setup  = (txn_kind == TK_SETUP);
        is_out    = (txn_kind == TK_OUT);
        violation = !is_setup && ((txn_status && !txn_toggle_ok) ||
                                  (!txn_status && data_end) ||
                                  (is_out && (txn_len > MAX_LIM)));
        if (is_setup)                 code_d = HS_ACK;
        else if (cpu_stall)           code_d = HS_STALL;
        else if (defer_q || violation) code_d = HS_STALL;
        else if (is_out ? out_rdy : !in_rdy) code_d = HS_NAK;
        else                          code_d = HS_ACK;

        ev_setup     = txn_valid && is_setup;
        ev_hw_stall  = txn_valid && !is_setup && !cpu_stall && (defer_q || violation);
        ack_data     = txn_valid && !is_setup && (code_d == HS_ACK);
        ev_out_ack   = ack_data && is_out && !txn_status;
        status_ack   = ack_data && txn_status;
        ev_early_end = (ev_setup || status_ack) && (state_q == CT_DATA) && !data_end;

        if (ev_setup)         defer_d = !txn_toggle_ok;
        else if (ev_hw_stall) defer_d = 1'b0;
        else                  defer_d = defer_q;

        state_d = state_q;
        if (ev_setup) begin
            state_d = CT_DATA;
        end else if (ev_hw_stall) begin
            state_d = CT_IDLE;
        end else begin
            unique case (state_q)
                CT_IDLE:   state_d = CT_IDLE;
                CT_DATA:   if (status_ack) state_d = CT_IDLE;
                           else if (data_end) state_d = CT_STATUS;
                CT_STATUS: if (status_ack) state_d = CT_IDLE;
                default:   state_d = CT_IDLE;
            endcase
        end
    end

    // transfer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CT_IDLE;
            defer_q <= 1'b0;
        end else begin
            state_q <= state_d;
            defer_q <= defer_d;
        end
    end

    // handshake outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            code_q   <= HS_ACK;
        end else begin
            hs_valid <= txn_valid;
            code_q   <= txn_valid ? code_d : HS_ACK;
        end
    end
    assign hs_code = code_q;

    assert_setup_always_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_kind == TK_SETUP) |=> (hs_valid && hs_code == HS_ACK));
    assert_deferred_stall_applied_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (defer_q && txn_valid && txn_kind != TK_SETUP) |=> (hs_code == HS_STALL));
    assert_handshake_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(txn_valid));
endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
    import ep0_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    input  logic       ev_setup,
    input  logic       ev_out_ack,
    input  logic       ev_hw_stall,
    input  logic       ev_early_end,
    input  logic       in_acked,
    output logic       out_rdy,
    output logic       in_rdy,
    output logic       cpu_stall,
    output logic       data_end,
    output logic       hw_stall,
    output logic       early_end,
    output logic [7:0] cpu_rdata
);
    logic out_d, in_d, cst_d, de_d, hws_d, ee_d;
    logic unused_ro_bits;
    assign unused_ro_bits = ^{cpu_wdata[B_OUT_RDY], cpu_wdata[B_EARLY]};

    // CPU effect first, hardware events applied last so they win
    always_comb begin
        out_d = out_rdy; in_d = in_rdy; cst_d = cpu_stall;
        de_d  = data_end; hws_d = hw_stall; ee_d = early_end;
        if (cpu_wr) begin
            if (cpu_wdata[B_SVC_OUT])  out_d = 1'b0;
            if (cpu_wdata[B_IN_RDY])   in_d  = 1'b1;
            cst_d = cpu_wdata[B_CPU_STL];
            if (cpu_wdata[B_DATA_END]) de_d  = 1'b1;
            if (!cpu_wdata[B_HW_STL])  hws_d = 1'b0;
            if (cpu_wdata[B_SVC_END])  ee_d  = 1'b0;
        end
        if (ev_setup || ev_out_ack)    out_d = 1'b1;
        if (ev_setup || in_acked)      in_d  = 1'b0;
        if (ev_setup || ev_hw_stall)   de_d  = 1'b0;
        if (ev_hw_stall)               hws_d = 1'b1;
        if (ev_early_end)              ee_d  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_rdy <= 1'b0; in_rdy <= 1'b0; cpu_stall <= 1'b0;
            data_end <= 1'b0; hw_stall <= 1'b0; early_end <= 1'b0;
        end else begin
            out_rdy <= out_d; in_rdy <= in_d; cpu_stall <= cst_d;
            data_end <= de_d; hw_stall <= hws_d; early_end <= ee_d;
        end
    end

    assign cpu_rdata = {2'b00, early_end, hw_stall, data_end, cpu_stall, in_rdy, out_rdy};

    assert_early_end_cleared_by_cpu_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(early_end) |-> $past(cpu_wr && cpu_wdata[B_SVC_END]));
    assert_out_rdy_cleared_by_cpu_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_rdy) |-> $past(cpu_wr && cpu_wdata[B_SVC_OUT]));
    assert_setup_sets_out_rdy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup |=> out_rdy);
endmodule

// File: rtl/ep0_ctrl_status.sv
module ep0_ctrl_status
    import ep0_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int LEN_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_valid,
    input  logic [1:0]       txn_kind,
    input  logic             txn_toggle_ok,
    input  logic             txn_status,
    input  logic [LEN_W-1:0] txn_len,
    input  logic             in_acked,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic             hs_valid,
    output logic [1:0]       hs_code
);
    logic out_rdy, in_rdy, cpu_stall, data_end, hw_stall, early_end;
    logic ev_setup, ev_out_ack, ev_hw_stall, ev_early_end;

    ep0_xfer_fsm #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_toggle_ok(txn_toggle_ok), .txn_status(txn_status), .txn_len(txn_len),
        .out_rdy(out_rdy), .in_rdy(in_rdy), .cpu_stall(cpu_stall), .data_end(data_end),
        .ev_setup(ev_setup), .ev_out_ack(ev_out_ack), .ev_hw_stall(ev_hw_stall),
        .ev_early_end(ev_early_end), .hs_valid(hs_valid), .hs_code(hs_code)
    );

    ep0_csr csr_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .ev_setup(ev_setup), .ev_out_ack(ev_out_ack), .ev_hw_stall(ev_hw_stall),
        .ev_early_end(ev_early_end), .in_acked(in_acked),
        .out_rdy(out_rdy), .in_rdy(in_rdy), .cpu_stall(cpu_stall), .data_end(data_end),
        .hw_stall(hw_stall), .early_end(early_end), .cpu_rdata(cpu_rdata)
    );

    assert_hw_stall_flag_with_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_stall) |-> (hs_valid && hs_code == HS_STALL));
    assert_cpu_stall_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && txn_valid && txn_kind != TK_SETUP) |=> (hs_code == HS_STALL));
endmodule

// File: tb/ep0_ctrl_status_tb.sv
module ep0_ctrl_status_tb_top;
    localparam int LEN_W = 10;
    localparam int S = 0, O = 1, I = 2;
    localparam int A = 0, N = 1, ST = 2;

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       tv;
        logic [1:0] tk;
        logic       tog;
        logic       st;
        logic [9:0] len;
        logic       ack;
        logic       ehv;
        logic [1:0] ehc;
        logic [7:0] ereg;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t v(int wr, int wd, int tv, int tk, int tog, int st,
                               int len, int ack, int ehc, int ereg, int req);
        vec_t r;
        r.wr = wr[0]; r.wd = wd[7:0]; r.tv = tv[0]; r.tk = tk[1:0];
        r.tog = tog[0]; r.st = st[0]; r.len = len[9:0]; r.ack = ack[0];
        r.ehv = tv[0]; r.ehc = ehc[1:0]; r.ereg = ereg[7:0]; r.req = req[3:0];
        return r;
    endfunction
    function automatic vec_t cw(int wd, int ereg, int req);
        return v(1, wd, 0, 0, 1, 0, 0, 0, 0, ereg, req);
    endfunction
    function automatic vec_t tx(int tk, int tog, int st, int len, int ehc, int ereg, int req);
        return v(0, 0, 1, tk, tog, st, len, 0, ehc, ereg, req);
    endfunction
    function automatic vec_t ak(int ereg, int req);
        return v(0, 0, 0, 0, 1, 0, 0, 1, 0, ereg, req);
    endfunction
    function automatic vec_t nop(int ereg, int req);
        return v(0, 0, 0, 0, 1, 0, 0, 0, 0, ereg, req);
    endfunction

    localparam int NV = 52;
    localparam vec_t TBL [NV] = '{
        nop('h00, 1),                       // R1 idle after reset
        tx(S,1,0,0, A,'h01, 2),             // R2
        tx(O,1,0,8, N,'h01, 8),             // R8 NAK while OUT_READY
        cw('h40,'h00, 12),                  // R12
        tx(O,1,0,8, A,'h01, 8),             // R8
        cw('h01,'h01, 12),                  // R12 bit0 write ignored
        cw('h40,'h00, 12),
        tx(I,1,0,0, N,'h00, 8),             // R8 NAK IN without data
        cw('h02,'h02, 9),                   // R9
        tx(I,1,0,0, A,'h02, 8),
        ak('h00, 9),                        // R9 host ack clears
        cw('h02,'h02, 9),
        cw('h00,'h02, 9),                   // R9 write 0 ignored
        tx(O,1,0,65, ST,'h12, 4),           // R4 oversize
        tx(O,1,0,64, A,'h13, 6),            // R6 one-shot, MAX_PKT accepted
        cw('h50,'h12, 10),                  // R10 write 1 ignored
        cw('h00,'h02, 10),                  // R10 write 0 clears
        tx(S,1,0,0, A,'h01, 2),             // R2 clears IN_READY
        tx(S,1,0,0, A,'h21, 11),            // R11 SETUP mid data stage
        cw('h20,'h21, 11),
        cw('hC0,'h00, 11),
        v(1,'h40,1,S,1,0,0,0, A,'h21, 13),  // R13 hw set beats cpu clear
        cw('hC0,'h00, 11),
        cw('h08,'h08, 14),                  // R14
        cw('h00,'h08, 14),
        tx(I,1,0,0, ST,'h10, 4),            // R4 IN after DATA_END
        tx(I,1,1,0, N,'h10, 6),             // R6
        cw('h00,'h00, 10),
        tx(S,0,0,0, A,'h01, 3),             // R3 bad toggle SETUP
        cw('h40,'h00, 3),
        tx(O,1,0,8, ST,'h10, 3),            // R3 deferred stall
        tx(O,1,0,8, A,'h11, 6),             // R6
        cw('h40,'h00, 12),
        cw('h04,'h04, 7),                   // R7
        tx(O,1,0,8, ST,'h04, 7),
        tx(I,1,0,0, ST,'h04, 7),
        tx(S,1,0,0, A,'h05, 2),
        cw('h40,'h00, 7),
        tx(O,0,1,0, ST,'h10, 5),            // R5
        cw('h00,'h00, 10),
        tx(S,1,0,0, A,'h01, 2),
        cw('h40,'h00, 12),
        tx(I,1,1,0, N,'h00, 8),
        cw('h02,'h02, 9),
        tx(I,1,1,0, A,'h22, 11),            // R11 early status
        ak('h20, 9),
        cw('h80,'h00, 11),
        tx(S,1,0,0, A,'h01, 2),
        cw('h48,'h08, 14),
        nop('h08, 11),
        tx(O,1,1,0, A,'h08, 11),            // R11 normal end, no flag
        tx(O,1,0,8, ST,'h10, 4)             // R4 OUT after DATA_END
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_valid = 1'b0, txn_toggle_ok = 1'b1, txn_status = 1'b0;
    logic [1:0] txn_kind = 2'd0;
    logic [LEN_W-1:0] txn_len = '0;
    logic in_acked = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic hs_valid;
    logic [1:0] hs_code;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ep0_ctrl_status #(.MAX_PKT(64), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_toggle_ok(txn_toggle_ok), .txn_status(txn_status), .txn_len(txn_len),
        .in_acked(in_acked), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .hs_valid(hs_valid), .hs_code(hs_code)
    );

    task automatic check(bit ok, int req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(vec_t r);
        cpu_wr = r.wr; cpu_wdata = r.wd; txn_valid = r.tv; txn_kind = r.tk;
        txn_toggle_ok = r.tog; txn_status = r.st; txn_len = r.len; in_acked = r.ack;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(cpu_rdata == 8'h00, 1, "reset reg", cpu_rdata, 0);   // R1
        check(hs_valid == 1'b0, 1, "reset hs_valid", hs_valid, 0);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            drive(TBL[k]);
            @(negedge clk);
            check(hs_valid == TBL[k].ehv, int'(TBL[k].req), "hs_valid", hs_valid, TBL[k].ehv);
            if (TBL[k].ehv)
                check(hs_code == TBL[k].ehc, int'(TBL[k].req), "hs_code", hs_code, TBL[k].ehc);
            check(cpu_rdata == TBL[k].ereg, int'(TBL[k].req), "register", cpu_rdata, TBL[k].ereg);
        end
        drive(nop(0, 0));

        // R1: reset in the middle of activity
        drive(cw('h0E, 'h0E, 1));
        @(negedge clk);
        check(cpu_rdata == 8'h0E, 1, "pre-reset reg", cpu_rdata, 'h0E);
        drive(tx(I, 1, 0, 0, ST, 0, 1));
        @(negedge clk);
        drive(nop(0, 0));
        rst_n = 1'b0;
        #1;
        check(cpu_rdata == 8'h00, 1, "mid-run reset reg", cpu_rdata, 0);
        check(hs_valid == 1'b0, 1, "mid-run reset hs_valid", hs_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: first SETUP after reset
        drive(tx(S, 1, 0, 0, A, 'h01, 2));
        @(negedge clk);
        check(hs_valid && hs_code == 2'd0, 2, "setup after reset", hs_code, 0);
        check(cpu_rdata == 8'h01, 2, "setup after reset reg", cpu_rdata, 'h01);
        drive(nop(0, 0));
        @(negedge clk);
        check(hs_valid == 1'b0, 2, "hs_valid one cycle", hs_valid, 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 20000, 0);
        finish_run();
    end
endmodule